// File: doc/BRIEF.md
# Configurable Framing Serial Transmitter

This block is an asynchronous serial transmit engine. A four-entry holding buffer sits in front of a frame shifter. Characters of up to nine bits are pushed in with a write strobe. The shifter builds each frame from a two-bit format code and a stop-length select, then moves it out on one line. An external divider supplies a baud tick, and sixteen ticks make one bit time.

Software-side logic drives the controls directly:
- an enable;
- a stop-when-idle control, paired with a chip idle request;
- a forced-low break.

The block reports back through three outputs:
- a buffer-full flag;
- a shifter-empty flag;
- a one-cycle interrupt pulse, raised on every buffer-to-shifter transfer or only on the transfer that drains the buffer.

Top module: `serial_tx_core`

## Requirements
- R1: With no frame in flight and no break, `txd` is high. A frame is a low start bit, then the data bits LSB first, then the parity bit when one is chosen, then the stop bits, which are high. Every bit lasts exactly 16 cycles in which `baud_tick` is high.
- R2: `fmt_sel` = 2'b00 sends `wr_data[7:0]` with no parity. `fmt_sel` = 2'b11 sends all nine bits of `wr_data`, with `wr_data[8]` as the last data bit and no parity.
- R3: `fmt_sel` = 2'b01 appends a parity bit that makes the count of ones in `wr_data[7:0]` plus parity even. `fmt_sel` = 2'b10 makes that count odd.
- R4: `two_stop` = 0 ends the frame with one stop bit and `two_stop` = 1 with two. `sr_empty` stays 0 through the final stop bit.
- R5: While `brk_force` is 1, `txd` is 0 in the same cycle, whatever the shifter is doing. Once it clears, the line follows the shifter again.
- R6: While `tx_en` is 0, no frame starts and `txd` stays high. Characters already buffered are kept, and they are sent in write order once `tx_en` returns to 1.
- R7: The buffer holds four characters. `buf_full` is 1 exactly while four are held. A write made while `buf_full` is 1 is discarded and never sent.
- R8: `sr_empty` is 1 out of reset and whenever no frame is in flight. It is 0 from the cycle after a character enters the shifter until the last stop bit has lasted its full 16 ticks.
- R9: With `irq_mode` = 0, `irq` pulses high for one cycle on every transfer from the buffer to the shifter.
- R10: With `irq_mode` = 1, `irq` pulses only on a transfer that leaves the buffer empty.
- R11: While `stop_in_idle` and `idle_req` are both 1, the frame in flight is dropped. From the next cycle `txd` is high and `sr_empty` is 1, and the dropped character is not resent. `idle_req` with `stop_in_idle` = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| idle_req | input | 1 | Chip idle request |
| stop_in_idle | input | 1 | Halt the transmitter while idle is requested |
| brk_force | input | 1 | Force the line low |
| fmt_sel | input | 2 | Frame format code |
| two_stop | input | 1 | 1 selects two stop bits |
| irq_mode | input | 1 | 0: every transfer, 1: transfer that empties the buffer |
| wr_stb | input | 1 | Write strobe for one character |
| wr_data | input | 9 | Character to buffer |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| txd | output | 1 | Serial line |
| buf_full | output | 1 | Holding buffer full |
| sr_empty | output | 1 | No frame in flight |
| irq | output | 1 | Transmit interrupt pulse |

## Verification
The frame shape shows up on `txd` within one bit time of the fault:
- A wrong frame length or format decode gives a misplaced or missing parity or stop bit.
- A tick counter that is off moves the edges, and sampling at mid-bit catches them.

A shifter that runs one bit too short or too long shows on `sr_empty`, sampled in the middle of the final stop bit and just after it. Buffer pointer or count faults show as:
- characters that are lost, repeated or out of order across four back-to-back frames;
- a fifth, dropped character that appears on the line anyway.

Interrupt qualification errors show as a wrong pulse count over one burst.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef enum logic [1:0] {
    FMT_D8      = 2'b00,
    FMT_D8_EVEN = 2'b01,
    FMT_D8_ODD  = 2'b10,
    FMT_D9      = 2'b11
  } frame_fmt_e;
endpackage

// File: rtl/tx_hold_fifo.sv
module tx_hold_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             full,
  output logic             empty,
  output logic             last
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CW-1:0]    count, count_n;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign last     = (count == CW'(1));
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign pop_data = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = push_ok ? ptr_inc(wr_ptr) : wr_ptr;
    rd_ptr_n = pop_ok  ? ptr_inc(rd_ptr) : rd_ptr;
    count_n  = count;
    if (push_ok && !pop_ok)      count_n = count + 1'b1;
    else if (pop_ok && !push_ok) count_n = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  // R7
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (count == $past(count)));

  // R7
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import serial_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  frame_fmt_e        fmt,
  input  logic              two_stop,
  input  logic              baud_tick,
  output logic              busy,
  output logic              line
);
  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned LW      = $clog2(FRAME_W + 1);
  localparam int unsigned TW      = (OVS > 1) ? $clog2(OVS) : 1;

  logic [FRAME_W-1:0] sr, sr_n, frame_new;
  logic [LW-1:0]      left, left_n, len_new;
  logic [TW-1:0]      tcnt, tcnt_n;
  logic               busy_n;

  always_comb begin
    frame_new    = '1;
    frame_new[0] = 1'b0;
    for (int i = 0; i < DATA_W - 1; i++) frame_new[1 + i] = load_data[i];
    unique case (fmt)
      FMT_D9:      frame_new[DATA_W] = load_data[DATA_W-1];
      FMT_D8_EVEN: frame_new[DATA_W] = ^load_data[DATA_W-2:0];
      FMT_D8_ODD:  frame_new[DATA_W] = ~^load_data[DATA_W-2:0];
      default:     frame_new[DATA_W] = 1'b1;
    endcase
    len_new = LW'(DATA_W) + ((fmt != FMT_D8) ? LW'(1) : LW'(0))
            + (two_stop ? LW'(2) : LW'(1));
  end

  always_comb begin
    busy_n = busy;
    sr_n   = sr;
    left_n = left;
    tcnt_n = tcnt;
    if (abort) begin
      busy_n = 1'b0;
      tcnt_n = '0;
    end else if (load) begin
      busy_n = 1'b1;
      sr_n   = frame_new;
      left_n = len_new;
      tcnt_n = '0;
    end else if (busy && baud_tick) begin
      if (tcnt == TW'(OVS - 1)) begin
        tcnt_n = '0;
        if (left == LW'(1)) begin
          busy_n = 1'b0;
        end else begin
          sr_n   = {1'b1, sr[FRAME_W-1:1]};
          left_n = left - 1'b1;
        end
      end else begin
        tcnt_n = tcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sr   <= '1;
      left <= '0;
      tcnt <= '0;
    end else begin
      busy <= busy_n;
      sr   <= sr_n;
      left <= left_n;
      tcnt <= tcnt_n;
    end
  end

  assign line = busy ? sr[0] : 1'b1;

  // R11
  abort_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !abort) |=> !line);

  // R8
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import serial_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              idle_req,
  input  logic              stop_in_idle,
  input  logic              brk_force,
  input  logic [1:0]        fmt_sel,
  input  logic              two_stop,
  input  logic              irq_mode,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  output logic              txd,
  output logic              buf_full,
  output logic              sr_empty,
  output logic              irq
);
  logic              active, load, busy, line;
  logic              fifo_empty, fifo_last;
  logic [DATA_W-1:0] head;

  assign active = tx_en && !(stop_in_idle && idle_req);
  assign load   = active && !busy && !fifo_empty;

  tx_hold_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_stb),
    .push_data (wr_data),
    .pop       (load),
    .pop_data  (head),
    .full      (buf_full),
    .empty     (fifo_empty),
    .last      (fifo_last)
  );

  tx_frame_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (!active),
    .load      (load),
    .load_data (head),
    .fmt       (frame_fmt_e'(fmt_sel)),
    .two_stop  (two_stop),
    .baud_tick (baud_tick),
    .busy      (busy),
    .line      (line)
  );

  assign irq      = load && (!irq_mode || (fifo_last && !wr_stb));
  assign sr_empty = !busy;
  assign txd      = brk_force ? 1'b0 : line;

  // R9
  irq_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !sr_empty);

  // R10
  irq_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_mode) |=> fifo_empty);

  // R6
  disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && sr_empty) |=> sr_empty);
endmodule

// File: tb/test_serial_tx_core.sv
module test_serial_tx_core;
  logic       clk = 1'b0;
  logic       rst_n, tx_en, idle_req, stop_in_idle, brk_force, two_stop, irq_mode;
  logic [1:0] fmt_sel;
  logic       wr_stb, baud_tick, slow_tick;
  logic [8:0] wr_data;
  logic       txd, buf_full, sr_empty, irq;
  int         n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  serial_tx_core i_serial_tx_core (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .idle_req(idle_req),
    .stop_in_idle(stop_in_idle), .brk_force(brk_force), .fmt_sel(fmt_sel),
    .two_stop(two_stop), .irq_mode(irq_mode), .wr_stb(wr_stb), .wr_data(wr_data),
    .baud_tick(baud_tick), .txd(txd), .buf_full(buf_full), .sr_empty(sr_empty),
    .irq(irq)
  );

  // {fmt, two_stop, data}
  localparam logic [11:0] VEC [6] = '{
    {2'b00, 1'b0, 9'h0A5}, {2'b01, 1'b0, 9'h0B7}, {2'b10, 1'b1, 9'h013},
    {2'b11, 1'b0, 9'h1C3}, {2'b11, 1'b1, 9'h03C}, {2'b01, 1'b1, 9'h001}
  };

  initial begin
    baud_tick = 1'b1;
    forever @(negedge clk) baud_tick = slow_tick ? ~baud_tick : 1'b1;
  end

  always @(negedge clk) if (rst_n === 1'b1 && irq === 1'b1) irq_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_char(input logic [8:0] d);
    @(negedge clk);
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic exp_frame(input logic [1:0] f, input logic two, input logic [8:0] d,
                           output logic [11:0] fr, output int n);
    int ones = 0;
    fr = '1;
    fr[0] = 1'b0;
    n = 1;
    for (int i = 0; i < 8; i++) begin
      fr[n] = d[i];
      n++;
      if (d[i]) ones++;
    end
    if (f == 2'b11) begin fr[n] = d[8]; n++; end
    else if (f == 2'b01) begin fr[n] = (ones % 2 == 1); n++; end
    else if (f == 2'b10) begin fr[n] = (ones % 2 == 0); n++; end
    n = n + (two ? 2 : 1);
  endtask

  task automatic rx_frame(input int n, input int per, output logic [11:0] got,
                          output bit started);
    int t = 0;
    got = '1;
    started = 0;
    while (txd !== 1'b0 && t < 400) begin @(negedge clk); t++; end
    if (txd !== 1'b0) return;
    started = 1;
    repeat (per / 2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (per) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic rx_expect(input logic [1:0] f, input logic two, input logic [8:0] d,
                           input int per, input string req);
    logic [11:0] e, g, m;
    int n;
    bit st;
    exp_frame(f, two, d, e, n);
    rx_frame(n, per, g, st);
    m = (12'(1) << n) - 12'(1);
    check(st, req, 0, 1);
    check((g & m) == (e & m), req, int'(g & m), int'(e & m));
    check(sr_empty == 1'b0, "R4 R8 busy in last stop", sr_empty, 0);
  endtask

  task automatic send_and_check(input logic [1:0] f, input logic two, input logic [8:0] d,
                                input int per, input string req);
    fmt_sel  = f;
    two_stop = two;
    write_char(d);
    rx_expect(f, two, d, per, req);
    repeat (per * 3 / 4) @(negedge clk);
    check(sr_empty == 1'b1 && txd == 1'b1, "R8 R1 idle after frame", {sr_empty, txd}, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] g;
    bit st;
    int t;
    rst_n = 1'b0; tx_en = 1'b1; idle_req = 1'b0; stop_in_idle = 1'b0; brk_force = 1'b0;
    fmt_sel = 2'b00; two_stop = 1'b0; irq_mode = 1'b0; wr_stb = 1'b0; wr_data = '0;
    slow_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 reset line high", txd, 1);
    check(sr_empty == 1'b1, "R8 reset empty", sr_empty, 1);
    check(buf_full == 1'b0, "R7 reset not full", buf_full, 0);
    check(irq == 1'b0, "R9 reset no irq", irq, 0);

    // R1 R2 R3 R4: table of formats
    for (int k = 0; k < 6; k++)
      send_and_check(VEC[k][11:10], VEC[k][9], VEC[k][8:0], 16, "R2 R3 R4 frame");

    // R1: tick every other cycle gives 32-cycle bits
    slow_tick = 1'b1;
    send_and_check(2'b00, 1'b0, 9'h05A, 32, "R1 tick-gated timing");
    slow_tick = 1'b0;
    repeat (4) @(negedge clk);

    // R11: idle request without stop control is ignored
    stop_in_idle = 1'b0;
    idle_req = 1'b1;
    send_and_check(2'b01, 1'b0, 9'h0C6, 16, "R11 idle ignored");
    idle_req = 1'b0;

    // R5: break when idle and mid-frame
    @(negedge clk);
    brk_force = 1'b1; #1;
    check(txd == 1'b0, "R5 break idle", txd, 0);
    brk_force = 1'b0; #1;
    check(txd == 1'b1, "R5 break release", txd, 1);
    fmt_sel = 2'b11; two_stop = 1'b0;
    write_char(9'h1FF);
    t = 0;
    while (txd !== 1'b0 && t < 100) begin @(negedge clk); t++; end
    repeat (24) @(negedge clk);
    check(txd == 1'b1, "R5 data bit before break", txd, 1);
    brk_force = 1'b1; #1;
    check(txd == 1'b0, "R5 break mid-frame", txd, 0);
    @(negedge clk);
    brk_force = 1'b0;
    t = 0;
    while (sr_empty !== 1'b1 && t < 400) begin @(negedge clk); t++; end

    // R11: abort in the start bit
    stop_in_idle = 1'b1;
    fmt_sel = 2'b00;
    write_char(9'h0FF);
    t = 0;
    while (txd !== 1'b0 && t < 100) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    idle_req = 1'b1;
    @(negedge clk);
    check(txd == 1'b1 && sr_empty == 1'b1, "R11 abort", {txd, sr_empty}, 3);
    repeat (30) @(negedge clk);
    idle_req = 1'b0;
    stop_in_idle = 1'b0;
    rx_frame(10, 16, g, st);
    check(st == 0, "R11 aborted char not resent", st, 0);

    // R6 R7 R9: disabled fill, overflow, then burst
    tx_en = 1'b0;
    irq_mode = 1'b0;
    write_char(9'h011); write_char(9'h022); write_char(9'h033);
    check(buf_full == 1'b0, "R7 three held", buf_full, 0);
    write_char(9'h044);
    check(buf_full == 1'b1, "R7 four held", buf_full, 1);
    write_char(9'h055);
    repeat (40) @(negedge clk);
    check(txd == 1'b1 && sr_empty == 1'b1, "R6 disabled silent", {txd, sr_empty}, 3);
    irq_cnt = 0;
    tx_en = 1'b1;
    rx_expect(2'b00, 1'b0, 9'h011, 16, "R6 order 1");
    rx_expect(2'b00, 1'b0, 9'h022, 16, "R6 order 2");
    rx_expect(2'b00, 1'b0, 9'h033, 16, "R6 order 3");
    rx_expect(2'b00, 1'b0, 9'h044, 16, "R6 order 4");
    rx_frame(10, 16, g, st);
    check(st == 0, "R7 overflow write dropped", st, 0);
    check(irq_cnt == 4, "R9 irq per load", irq_cnt, 4);

    // R10: irq only on draining load
    tx_en = 1'b0;
    irq_mode = 1'b1;
    write_char(9'h0A1); write_char(9'h0B2);
    irq_cnt = 0;
    tx_en = 1'b1;
    rx_expect(2'b00, 1'b0, 9'h0A1, 16, "R10 frame 1");
    rx_expect(2'b00, 1'b0, 9'h0B2, 16, "R10 frame 2");
    repeat (20) @(negedge clk);
    check(irq_cnt == 1, "R10 irq on drain only", irq_cnt, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule